// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the bit-level timing and bus-ownership core of an I2C master. A byte-level sequencer above it issues one command at a time: start, repeated start, stop, write one bit or read one bit. The engine turns each command into SCL and SDA waveforms. Both lines are open-drain: each output either pulls its line low or lets it go. One programmable reload value sets the length of every timed phase.

The engine samples both bus lines through a two-flop synchronizer. When it lets SCL go, its phase timer stops until SCL is actually seen high, so a slave that stretches the clock only delays the bit. The high phase is then timed from that moment. During a written bit, the engine compares what it let go on SDA with what it samples. If another master pulls SDA low while this one sends a 1, the engine has lost arbitration. It drops both lines, raises a sticky collision flag and returns to idle.

Each finished command produces a one-cycle done pulse. A one-cycle master-event interrupt pulse accompanies every done pulse and every collision.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset, neither line is driven low, and done_o, irq_o and coll_o are low.
- R2: Command code 1 (start) is accepted only when idle. SDA is driven low with SCL released for reload+1 cycles. Then SCL is driven low and done_o pulses reload+2 cycles after the command cycle.
- R3: Command code 4 (write) sends wdata_i. SDA is driven low for a 0 and released for a 1, and that level holds for the whole bit and after it. With no stretching, done_o pulses 2*reload+6 cycles after the command cycle.
- R4: While SCL is released but sampled low, the engine waits with no time limit and does not finish the bit. After the SCL input rises, SCL stays released for exactly reload+4 cycles before the engine drives it low again.
- R5: Command code 5 (read) releases SDA for the bit. The SDA level sampled in the last high-phase cycle appears on rdata_o together with done_o, 2*reload+6 cycles after the command cycle.
- R6: Command code 2 (restart) releases SDA during one clock low and high phase. It then drives SDA low with SCL high for reload+1 cycles and ends with both lines low. done_o pulses 3*reload+7 cycles after the command cycle.
- R7: Command code 3 (stop) drives SDA low through one clock low and high phase. It then releases SDA and keeps SCL released for reload+1 cycles. done_o pulses 3*reload+7 cycles after the command cycle, and the engine is idle again, where a write command has no effect.
- R8: In a write of 1, a low SDA sample during the high phase sets coll_o reload+6 cycles after the command cycle. Both lines are released and no done_o pulse follows.
- R9: While coll_o is set, all commands are ignored. A coll_clr_i pulse clears coll_o on the next cycle.
- R10: irq_o pulses for exactly the cycle of each done_o pulse and of each rise of coll_o, and at no other time.
- R11: Command codes 0, 6 and 7 are ignored, and so is any command other than start in idle or start in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | CNT_W | Phase timer reload value |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_i | input | 3 | Command code |
| wdata_i | input | 1 | Bit to send with a write |
| coll_clr_i | input | 1 | Clears the collision flag |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_drive_low_o | output | 1 | Pull SCL low when high |
| sda_drive_low_o | output | 1 | Pull SDA low when high |
| done_o | output | 1 | Command finished, one-cycle pulse |
| rdata_o | output | 1 | Sampled read bit, valid with done_o |
| irq_o | output | 1 | Master-event pulse |
| coll_o | output | 1 | Sticky arbitration-loss flag |

## Verification
Each result has a fixed due time counted from the cycle in which the command is presented. Start finishes after reload+2 cycles, a bit after 2*reload+6, and a restart or stop after 3*reload+7. A collision shows on coll_o after reload+6; the three extra cycles cover the synchronizer and the decision cycle. The scoreboard records the issue cycle and stores each expected event with its latency. When an event arrives, it compares the elapsed cycle count exactly. The test with a stretched clock cannot be given a fixed latency. There, the bench measures the time from the SCL input rising to SCL being driven low again, which must be reload+4 cycles.

// File: rtl/i2c_be_pkg.sv
package i2c_be_pkg;
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_START   = 3'd1,
    CMD_RESTART = 3'd2,
    CMD_STOP    = 3'd3,
    CMD_WRITE   = 3'd4,
    CMD_READ    = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus not owned, both released
    ST_OWN,    // bus owned, SCL held low between commands
    ST_SHOLD,  // start hold: SCL released, SDA low
    ST_LOW,    // clock low phase
    ST_WAIT,   // SCL released, waiting to see it high
    ST_HIGH,   // clock high phase
    ST_PHOLD   // stop hold: both released
  } st_e;
endpackage

// File: rtl/i2c_be_sync.sv
module i2c_be_sync #(
  parameter int unsigned     WIDTH   = 2,
  parameter int unsigned     STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= {STAGES{RST_VAL[i]}};
      else         chain <= {chain[STAGES-2:0], d_i[i]};
    end
    assign q_o[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/i2c_be_brg.sv
module i2c_be_brg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             load_i,
  input  logic             hold_i,
  output logic             roll_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (load_i)                   cnt_q <= reload_i;
    else if (!hold_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign roll_o = (cnt_q == '0);
endmodule

// File: rtl/i2c_be_fsm.sv
module i2c_be_fsm
  import i2c_be_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       wdata_i,
  input  logic       coll_clr_i,
  input  logic       scl_s_i,
  input  logic       sda_s_i,
  input  logic       roll_i,
  output logic       load_o,
  output logic       hold_o,
  output logic       scl_low_o,
  output logic       sda_low_o,
  output logic       done_o,
  output logic       irq_o,
  output logic       coll_o,
  output logic       rdata_o
);
  st_e  state_q, state_d;
  cmd_e op_q, op_d, cmd;
  logic sda_q, sda_d;
  logic rbit_q, rbit_d;
  logic done_q, irq_q, coll_q;
  logic set_done, set_coll, accept;

  assign cmd    = cmd_e'(cmd_i);
  assign accept = cmd_valid_i && !coll_q;

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    sda_d    = sda_q;
    rbit_d   = rbit_q;
    load_o   = 1'b0;
    set_done = 1'b0;
    set_coll = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && cmd == CMD_START) begin
          state_d = ST_SHOLD;
          op_d    = CMD_START;
          sda_d   = 1'b1;
          load_o  = 1'b1;
        end
      end
      ST_OWN: begin
        if (accept && (cmd == CMD_WRITE || cmd == CMD_READ ||
                       cmd == CMD_RESTART || cmd == CMD_STOP)) begin
          state_d = ST_LOW;
          op_d    = cmd;
          load_o  = 1'b1;
          unique case (cmd)
            CMD_WRITE: sda_d = ~wdata_i;
            CMD_STOP:  sda_d = 1'b1;
            default:   sda_d = 1'b0;
          endcase
        end
      end
      ST_SHOLD: begin
        if (roll_i) begin
          state_d  = ST_OWN;
          set_done = 1'b1;
        end
      end
      ST_LOW: begin
        if (roll_i) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        // timer suspended until the line is really high
        if (scl_s_i) begin
          state_d = ST_HIGH;
          load_o  = 1'b1;
        end
      end
      ST_HIGH: begin
        if (op_q == CMD_WRITE && !sda_q && !sda_s_i) begin
          state_d  = ST_IDLE;
          sda_d    = 1'b0;
          set_coll = 1'b1;
        end else if (roll_i) begin
          unique case (op_q)
            CMD_RESTART: begin
              state_d = ST_SHOLD;
              sda_d   = 1'b1;
              load_o  = 1'b1;
            end
            CMD_STOP: begin
              state_d = ST_PHOLD;
              sda_d   = 1'b0;
              load_o  = 1'b1;
            end
            default: begin
              state_d  = ST_OWN;
              rbit_d   = sda_s_i;
              set_done = 1'b1;
            end
          endcase
        end
      end
      ST_PHOLD: begin
        if (roll_i) begin
          state_d  = ST_IDLE;
          set_done = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= CMD_NONE;
      sda_q   <= 1'b0;
      rbit_q  <= 1'b0;
      done_q  <= 1'b0;
      irq_q   <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      op_q    <= op_d;
      sda_q   <= sda_d;
      rbit_q  <= rbit_d;
      done_q  <= set_done;
      irq_q   <= set_done | set_coll;
      if (set_coll)        coll_q <= 1'b1;
      else if (coll_clr_i) coll_q <= 1'b0;
    end
  end

  assign hold_o    = (state_q == ST_WAIT) || (state_q == ST_IDLE) || (state_q == ST_OWN);
  assign scl_low_o = (state_q == ST_OWN) || (state_q == ST_LOW);
  assign sda_low_o = sda_q;
  assign done_o    = done_q;
  assign irq_o     = irq_q;
  assign coll_o    = coll_q;
  assign rdata_o   = rbit_q;
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic             wdata_i,
  input  logic             coll_clr_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_drive_low_o,
  output logic             sda_drive_low_o,
  output logic             done_o,
  output logic             rdata_o,
  output logic             irq_o,
  output logic             coll_o
);
  localparam int unsigned LINES = 2;

  logic [LINES-1:0] pins_s;
  logic             load, hold, roll;

  i2c_be_sync #(
    .WIDTH  (LINES),
    .STAGES (SYNC_STAGES),
    .RST_VAL({LINES{1'b1}})
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (pins_s)
  );

  i2c_be_brg #(.CNT_W(CNT_W)) u_brg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .reload_i(reload_i),
    .load_i  (load),
    .hold_i  (hold),
    .roll_o  (roll)
  );

  i2c_be_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_valid_i(cmd_valid_i),
    .cmd_i      (cmd_i),
    .wdata_i    (wdata_i),
    .coll_clr_i (coll_clr_i),
    .scl_s_i    (pins_s[1]),
    .sda_s_i    (pins_s[0]),
    .roll_i     (roll),
    .load_o     (load),
    .hold_o     (hold),
    .scl_low_o  (scl_drive_low_o),
    .sda_low_o  (sda_drive_low_o),
    .done_o     (done_o),
    .irq_o      (irq_o),
    .coll_o     (coll_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/i2c_bit_engine_chk.sv
module i2c_bit_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic coll_clr_i,
  input logic scl_drive_low_o,
  input logic sda_drive_low_o,
  input logic done_o,
  input logic irq_o,
  input logic coll_o
);
  p_coll_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_o |-> (!scl_drive_low_o && !sda_drive_low_o));

  p_coll_no_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) |-> !done_o);

  p_coll_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_o && !coll_clr_i) |=> coll_o);

  p_coll_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_o && coll_clr_i) |=> !coll_o);

  p_irq_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> irq_o);

  p_irq_coll_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(coll_o) |-> irq_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind i2c_bit_engine i2c_bit_engine_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .coll_clr_i     (coll_clr_i),
  .scl_drive_low_o(scl_drive_low_o),
  .sda_drive_low_o(sda_drive_low_o),
  .done_o         (done_o),
  .irq_o          (irq_o),
  .coll_o         (coll_o)
);

// File: tb/i2c_bit_engine_test.sv
`timescale 1ns/1ps
module i2c_bit_engine_test;
  localparam logic [2:0] C_START = 3'd1, C_RESTART = 3'd2, C_STOP = 3'd3,
                         C_WRITE = 3'd4, C_READ = 3'd5;

  logic clk_i = 1'b0;
  always #4 clk_i = ~clk_i;

  logic rst_ni, cmd_valid_i, wdata_i, coll_clr_i;
  logic [2:0] cmd_i;
  logic [7:0] reload_i;
  logic scl_i, sda_i, scl_drive_low_o, sda_drive_low_o;
  logic done_o, rdata_o, irq_o, coll_o;
  logic ext_scl_low, ext_sda_low;
  int rl;

  assign reload_i = rl[7:0];
  assign scl_i = !scl_drive_low_o && !ext_scl_low;
  assign sda_i = !sda_drive_low_o && !ext_sda_low;

  i2c_bit_engine uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .reload_i(reload_i),
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .wdata_i(wdata_i),
    .coll_clr_i(coll_clr_i), .scl_i(scl_i), .sda_i(sda_i),
    .scl_drive_low_o(scl_drive_low_o), .sda_drive_low_o(sda_drive_low_o),
    .done_o(done_o), .rdata_o(rdata_o), .irq_o(irq_o), .coll_o(coll_o)
  );

  typedef struct {
    int    kind;  // 0 done, 1 collision
    int    lat;   // -1: not checked
    int    rbit;  // -1: not checked
    string req;
  } exp_t;
  exp_t exp_q[$];

  int n_cmp = 0, n_bad = 0;
  int cyc = 0, issue_cyc = 0;
  bit finished = 0, meas_on = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic expect_ev(int kind, int lat, int rbit, string req);
    exp_t e;
    e.kind = kind; e.lat = lat; e.rbit = rbit; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic issue(logic [2:0] c, logic b);
    @(negedge clk_i);
    cmd_i = c; wdata_i = b; cmd_valid_i = 1'b1; issue_cyc = cyc;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: sampled just after the falling edge
  logic prev_coll = 1'b0, prev_scl_in = 1'b1, prev_scl_drv = 1'b0;
  int t_rise = 0;
  always @(negedge clk_i) begin
    #1;
    if (rst_ni) begin
      if (done_o || (coll_o && !prev_coll)) begin
        if (exp_q.size() == 0) begin
          chk("R11", "unexpected event", 1, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.req, "event kind", done_o ? 0 : 1, e.kind);
          if (e.lat >= 0)  chk(e.req, "latency", cyc - issue_cyc, e.lat);
          if (e.rbit >= 0) chk(e.req, "read bit", int'(rdata_o), e.rbit);
          chk("R10", "irq with event", int'(irq_o), 1);
        end
      end else if (irq_o) begin
        chk("R10", "irq without event", 1, 0);
      end
      if (meas_on) begin
        if (scl_i && !prev_scl_in) t_rise = cyc;
        if (scl_drive_low_o && !prev_scl_drv)
          chk("R4", "SCL high time from rise", cyc - t_rise, rl + 4);
      end
    end
    prev_coll    = coll_o;
    prev_scl_in  = scl_i;
    prev_scl_drv = scl_drive_low_o;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      chk("R1", "watchdog expired", 0, 1);
      summary();
    end
  end

  initial begin
    rst_ni = 1'b0; cmd_valid_i = 1'b0; cmd_i = 3'd0; wdata_i = 1'b0;
    coll_clr_i = 1'b0; ext_scl_low = 1'b0; ext_sda_low = 1'b0; rl = 3;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "scl drive after reset", int'(scl_drive_low_o), 0);
    chk("R1", "sda drive after reset", int'(sda_drive_low_o), 0);
    chk("R1", "done/irq/coll after reset", int'({done_o, irq_o, coll_o}), 0);

    // R11: write and illegal code in idle are ignored
    issue(C_WRITE, 1'b0);
    issue(3'd7, 1'b0);
    repeat (30) @(negedge clk_i);
    chk("R11", "idle lines after ignored cmds", int'({scl_drive_low_o, sda_drive_low_o}), 0);

    // R2: start
    expect_ev(0, rl + 2, -1, "R2");
    issue(C_START, 1'b0);
    chk("R2", "start hold sda/scl", int'({sda_drive_low_o, scl_drive_low_o}), 2);
    drain();
    chk("R2", "after start lines", int'({scl_drive_low_o, sda_drive_low_o}), 3);

    // R11: illegal code and start while owned are ignored
    issue(3'd6, 1'b0);
    issue(C_START, 1'b0);
    repeat (20) @(negedge clk_i);
    chk("R11", "owned lines after ignored cmds", int'({scl_drive_low_o, sda_drive_low_o}), 3);

    // R3: write 0 and 1
    meas_on = 1;
    expect_ev(0, 2 * rl + 6, -1, "R3");
    issue(C_WRITE, 1'b0);
    chk("R3", "sda low during write 0", int'(sda_drive_low_o), 1);
    drain();
    chk("R3", "sda after write 0", int'(sda_drive_low_o), 1);
    expect_ev(0, 2 * rl + 6, -1, "R3");
    issue(C_WRITE, 1'b1);
    drain();
    chk("R3", "sda after write 1", int'(sda_drive_low_o), 0);

    // R5: reads
    ext_sda_low = 1'b1;
    expect_ev(0, 2 * rl + 6, 0, "R5");
    issue(C_READ, 1'b0);
    drain();
    ext_sda_low = 1'b0;
    expect_ev(0, 2 * rl + 6, 1, "R5");
    issue(C_READ, 1'b0);
    drain();

    // new reload value
    rl = 6;
    expect_ev(0, 2 * rl + 6, -1, "R3");
    issue(C_WRITE, 1'b1);
    drain();

    // R4: stretched clock
    ext_scl_low = 1'b1;
    expect_ev(0, -1, -1, "R4");
    issue(C_WRITE, 1'b0);
    repeat (3 * rl + 20) @(negedge clk_i);
    chk("R4", "scl released while stretched", int'(scl_drive_low_o), 0);
    chk("R4", "bit pending while stretched", exp_q.size(), 1);
    ext_scl_low = 1'b0;
    drain();
    meas_on = 0;

    // R6: restart
    expect_ev(0, 3 * rl + 7, -1, "R6");
    issue(C_RESTART, 1'b0);
    drain();
    chk("R6", "after restart lines", int'({scl_drive_low_o, sda_drive_low_o}), 3);

    // R7: stop, then idle ignores write
    expect_ev(0, 3 * rl + 7, -1, "R7");
    issue(C_STOP, 1'b0);
    chk("R7", "stop low phase sda", int'(sda_drive_low_o), 1);
    drain();
    chk("R7", "after stop lines", int'({scl_drive_low_o, sda_drive_low_o}), 0);
    issue(C_WRITE, 1'b0);
    repeat (2 * rl + 20) @(negedge clk_i);
    chk("R7", "write after stop ignored", int'({scl_drive_low_o, sda_drive_low_o}), 0);

    // R8: arbitration loss
    rl = 3;
    expect_ev(0, rl + 2, -1, "R2");
    issue(C_START, 1'b0);
    drain();
    ext_sda_low = 1'b1;
    expect_ev(1, rl + 6, -1, "R8");
    issue(C_WRITE, 1'b1);
    drain();
    chk("R8", "coll flag", int'(coll_o), 1);
    chk("R8", "lines after collision", int'({scl_drive_low_o, sda_drive_low_o}), 0);
    ext_sda_low = 1'b0;

    // R9: ignored while flagged, then cleared
    issue(C_START, 1'b0);
    repeat (20) @(negedge clk_i);
    chk("R9", "start ignored while flagged", int'(sda_drive_low_o), 0);
    chk("R9", "flag held", int'(coll_o), 1);
    coll_clr_i = 1'b1;
    @(negedge clk_i);
    coll_clr_i = 1'b0;
    chk("R9", "flag cleared", int'(coll_o), 0);
    expect_ev(0, rl + 2, -1, "R9");
    issue(C_START, 1'b0);
    drain();
    expect_ev(0, 3 * rl + 7, -1, "R7");
    issue(C_STOP, 1'b0);
    drain();
    chk("R9", "scoreboard empty", exp_q.size(), 0);

    finished = 1;
    summary();
  end
endmodule